// File: doc/BRIEF.md
# Table Base Register Sanitiser

This block keeps two 64-bit base registers that tell an interrupt controller where its in-memory tables live. One holds the base of the property table and the other the base of the pending table. Software reaches both through one register port. A write can cover the full 64-bit word or only one 32-bit half, and the half is chosen by address bit 2.

A write is first merged into the register's current contents. The merged word then passes through a sanitising stage before it is stored. That stage forces the shareability and the two cacheability fields onto encodings the memory system supports, and it zeroes the bits each register reserves. Reads therefore always return a sanitised value.

While the low-power-interrupt enable input is high, the registers are frozen and every write is dropped. Table walking and the memory traffic itself belong to other blocks.

Top module: `tbl_base_regs`

## Requirements
- R1: While `lpi_on` is 1, a write to either register leaves both registers unchanged; writes are accepted again once `lpi_on` returns to 0.
- R2: A write with `acc_wide`=0 merges `wr_data[31:0]` into the lower half when `acc_hi`=0, or into the upper half when `acc_hi`=1. The other half keeps its value.
- R3: A write with `acc_wide`=1 replaces the whole 64-bit register, before sanitising.
- R4: Shareability sits at bits 11:10, with 0 = none, 1 = inner and 2 = outer. After the merge, the value 2 is stored as 1, and the values 0, 1 and 3 are stored unchanged.
- R5: Inner cacheability sits at bits 9:7. The values 0 (device) and 1 (non-cacheable) are stored as 3 (read-allocate write-back). All other values are stored unchanged.
- R6: Outer cacheability sits at bits 58:56. The values 0 (same as inner) and 1 (non-cacheable) are stored unchanged. Any other value is stored as 1.
- R7: In the property register (`acc_sel`=0), bits 63:59, 55:48 and 6:5 always read as zero.
- R8: In the pending register (`acc_sel`=1), bit 63, bits 61:59, 55:48, 15:12 and 6:0 always read as zero. Bit 62 is kept.
- R9: After reset, both registers hold 64'h180, which is the sanitised form of zero.
- R10: `rd_data` is combinational from the register picked by `acc_sel`. A 64-bit read returns the whole word. A 32-bit read returns the half picked by `acc_hi`, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpi_on | input | 1 | Low-power-interrupt enable; blocks writes when 1 |
| acc_sel | input | 1 | Register select: 0 property, 1 pending |
| acc_hi | input | 1 | Address bit 2: upper half for 32-bit accesses |
| acc_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data (32-bit writes use bits 31:0) |
| rd_data | output | 64 | Read data |

## Verification
The assertions watch every cycle for the following:
- the freeze under `lpi_on` and the untouched half or register after a narrow write;
- a forbidden shareability or cacheability code ever reaching storage;
- a reserved bit ever being set in either register.

Only the bench's scenarios can show that each coercion maps to the right replacement code. The same holds for merged values that keep the surrounding address bits, and for the zero-extension seen on 32-bit reads. The bench also shows the reset contents.

// File: rtl/tbl_pkg.sv
// Shared encodings, field positions and reserved masks for the table base
// register block. Assumes the 64-bit register layout used by tbl_base_regs.
package tbl_pkg;
    localparam int REG_W   = 64;
    localparam int HALF_W  = REG_W / 2;
    localparam int NUM_REG = 2;

    // Field positions
    localparam int SH_LO  = 10;
    localparam int SH_W   = 2;
    localparam int ICC_LO = 7;
    localparam int OCC_LO = 56;
    localparam int CC_W   = 3;

    // Shareability codes
    localparam logic [SH_W-1:0] SH_INNER = 2'd1;
    localparam logic [SH_W-1:0] SH_OUTER = 2'd2;

    // Cacheability codes
    localparam logic [CC_W-1:0] CC_DEV_SAME = 3'd0;
    localparam logic [CC_W-1:0] CC_NONCACHE = 3'd1;
    localparam logic [CC_W-1:0] CC_RA_WB    = 3'd3;

    // Reserved-bit masks (bits forced to zero)
    localparam logic [REG_W-1:0] PROP_CLR = 64'hF8FF_0000_0000_0060;
    localparam logic [REG_W-1:0] PEND_CLR = 64'hB8FF_0000_0000_F07F;

    // Value held after reset: zero after sanitising
    localparam logic [REG_W-1:0] RST_VAL = 64'h0000_0000_0000_0180;

    // Outer shareable folds to inner shareable
    function automatic logic [SH_W-1:0] fix_sh(input logic [SH_W-1:0] v);
        return (v == SH_OUTER) ? SH_INNER : v;
    endfunction

    // Device or non-cacheable inner attribute becomes write-back
    function automatic logic [CC_W-1:0] fix_icc(input logic [CC_W-1:0] v);
        return (v == CC_DEV_SAME || v == CC_NONCACHE) ? CC_RA_WB : v;
    endfunction

    // Outer attribute limited to same-as-inner or non-cacheable
    function automatic logic [CC_W-1:0] fix_occ(input logic [CC_W-1:0] v);
        return (v == CC_DEV_SAME || v == CC_NONCACHE) ? v : CC_NONCACHE;
    endfunction
endpackage

// File: rtl/tbl_half_merge.sv
// Merges write data into the current register value.
// Assumes: narrow writes carry their data in the low half of wr_data.
module tbl_half_merge
    import tbl_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] wdata,
    input  logic             hi,
    input  logic             wide,
    output logic [REG_W-1:0] merged
);
    // Select which half (or whole word) takes the new data
    always_comb begin
        if (wide)
            merged = wdata;
        else if (hi)
            merged = {wdata[HALF_W-1:0], cur[HALF_W-1:0]};
        else
            merged = {cur[REG_W-1:HALF_W], wdata[HALF_W-1:0]};
    end
endmodule

// File: rtl/tbl_attr_sanitise.sv
// Coerces attribute fields to supported codes and clears reserved bits.
// Assumes: CLR_MASK never covers the shareability or cacheability fields.
module tbl_attr_sanitise
    import tbl_pkg::*;
#(
    parameter logic [REG_W-1:0] CLR_MASK = PROP_CLR
) (
    input  logic [REG_W-1:0] din,
    output logic [REG_W-1:0] dout
);
    logic [REG_W-1:0] fixed;

    // Replace the three attribute fields with their coerced codes
    always_comb begin
        fixed = din;
        fixed[SH_LO  +: SH_W] = fix_sh (din[SH_LO  +: SH_W]);
        fixed[ICC_LO +: CC_W] = fix_icc(din[ICC_LO +: CC_W]);
        fixed[OCC_LO +: CC_W] = fix_occ(din[OCC_LO +: CC_W]);
    end

    // Zero every reserved bit
    assign dout = fixed & ~CLR_MASK;
endmodule

// File: rtl/tbl_base_regs.sv
// Property and pending table base registers with write sanitising.
// Assumes: one access per cycle; rd_data is a combinational view of storage.
module tbl_base_regs
    import tbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lpi_on,
    input  logic             acc_sel,
    input  logic             acc_hi,
    input  logic             acc_wide,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] reg_q [NUM_REG];

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        localparam logic [REG_W-1:0] MASK = (g == 0) ? PROP_CLR : PEND_CLR;
        logic [REG_W-1:0] merged;
        logic [REG_W-1:0] clean;
        logic             take;

        tbl_half_merge u_merge (
            .cur    (reg_q[g]),
            .wdata  (wr_data),
            .hi     (acc_hi),
            .wide   (acc_wide),
            .merged (merged)
        );

        tbl_attr_sanitise #(.CLR_MASK(MASK)) u_san (
            .din  (merged),
            .dout (clean)
        );

        assign take = wr_en && !lpi_on && (acc_sel == 1'(g));

        // Hold or load the sanitised word
        always_ff @(posedge clk) begin
            if (!rst_n)
                reg_q[g] <= RST_VAL;
            else if (take)
                reg_q[g] <= clean;
        end

        AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && lpi_on) |=> $stable(reg_q[g])); // R1
        AST_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !acc_wide && !acc_hi) |=> $stable(reg_q[g][REG_W-1:HALF_W])); // R2
        AST_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !acc_wide && acc_hi) |=> $stable(reg_q[g][HALF_W-1:0])); // R2
        AST_OTHER_REG: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && acc_sel != 1'(g)) |=> $stable(reg_q[g])); // R3
        AST_NO_OUTER_SH: assert property (@(posedge clk) disable iff (!rst_n)
            reg_q[g][SH_LO +: SH_W] != SH_OUTER); // R4
        AST_INNER_CC: assert property (@(posedge clk) disable iff (!rst_n)
            reg_q[g][ICC_LO +: CC_W] > CC_NONCACHE); // R5
        AST_OUTER_CC: assert property (@(posedge clk) disable iff (!rst_n)
            reg_q[g][OCC_LO +: CC_W] <= CC_NONCACHE); // R6
    end

    AST_PROP_RES0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q[0] & PROP_CLR) == '0); // R7
    AST_PEND_RES0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q[1] & PEND_CLR) == '0); // R8

    logic [REG_W-1:0] sel_q;

    // Pick the register and the half for the read port
    always_comb begin
        sel_q = reg_q[acc_sel];
        if (acc_wide)
            rd_data = sel_q;
        else if (acc_hi)
            rd_data = {{HALF_W{1'b0}}, sel_q[REG_W-1:HALF_W]};
        else
            rd_data = {{HALF_W{1'b0}}, sel_q[HALF_W-1:0]};
    end
endmodule

// File: tb/tbl_base_regs_bench.sv
module tbl_base_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lpi_on = 1'b0;
    logic        acc_sel = 1'b0;
    logic        acc_hi = 1'b0;
    logic        acc_wide = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tbl_base_regs u_tbl_base_regs (
        .clk(clk), .rst_n(rst_n), .lpi_on(lpi_on), .acc_sel(acc_sel),
        .acc_hi(acc_hi), .acc_wide(acc_wide), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    // Table of 64-bit writes: {sel, write data, expected stored value}
    localparam int NV = 8;
    localparam logic [128:0] VEC [NV] = '{
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0100_FFFF_FFFF_FF9F}, // R6 R7
        {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4100_FFFF_FFFF_0F80}, // R6 R8
        {1'b0, 64'h0000_0012_3456_7880, 64'h0000_0012_3456_7580}, // R4 R5
        {1'b1, 64'h0000_0012_3456_7880, 64'h0000_0012_3456_0580}, // R4 R8
        {1'b0, 64'h0200_0000_0000_0000, 64'h0100_0000_0000_0180}, // R5 R6
        {1'b1, 64'h4100_0000_ABCD_0E80, 64'h4100_0000_ABCD_0E80}, // R4 R5 R6
        {1'b0, 64'h0000_00FF_0000_0100, 64'h0000_00FF_0000_0100}, // R3 R5
        {1'b1, 64'h0300_0000_0000_0180, 64'h0100_0000_0000_0180}  // R6
    };

    task automatic do_write(input logic sel, input logic hi, input logic wide,
                            input logic [63:0] d);
        @(negedge clk);
        acc_sel = sel; acc_hi = hi; acc_wide = wide; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_rd(input logic sel, input logic hi, input logic wide,
                            input logic [63:0] exp, input string req);
        acc_sel = sel; acc_hi = hi; acc_wide = wide;
        #1;
        n_run++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, rd_data, exp);
        end
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset contents, R10 read shapes
        check_rd(1'b0, 1'b0, 1'b1, 64'h180, "R9");
        check_rd(1'b1, 1'b0, 1'b1, 64'h180, "R9");
        check_rd(1'b1, 1'b0, 1'b0, 64'h180, "R10");
        check_rd(1'b1, 1'b1, 1'b0, 64'h0,   "R10");

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][128], 1'b0, 1'b1, VEC[i][127:64]);
            check_rd(VEC[i][128], 1'b0, 1'b1, VEC[i][63:0], "R3");
        end

        // R2 narrow write to lower half of property register
        do_write(1'b0, 1'b0, 1'b0, 64'hDEAD_0000_0000_0C00);
        check_rd(1'b0, 1'b0, 1'b1, 64'h0000_00FF_0000_0D80, "R2");
        check_rd(1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_00FF, "R10");
        check_rd(1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0D80, "R10");

        // R2 narrow write to upper half, outer code 7 folds (R6)
        do_write(1'b0, 1'b1, 1'b0, 64'h0000_0000_0700_1234);
        check_rd(1'b0, 1'b0, 1'b1, 64'h0100_1234_0000_0D80, "R2");
        check_rd(1'b1, 1'b0, 1'b1, 64'h0100_0000_0000_0180, "R2");

        // R1 writes frozen while lpi_on is high
        lpi_on = 1'b1;
        do_write(1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        check_rd(1'b0, 1'b0, 1'b1, 64'h0100_1234_0000_0D80, "R1");
        do_write(1'b1, 1'b1, 1'b0, 64'h0000_0000_1234_5678);
        check_rd(1'b1, 1'b0, 1'b1, 64'h0100_0000_0000_0180, "R1");

        // R1 writes resume once released
        lpi_on = 1'b0;
        do_write(1'b1, 1'b0, 1'b1, 64'h0);
        check_rd(1'b1, 1'b0, 1'b1, 64'h180, "R1");

        // R9 reset restores both registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_rd(1'b0, 1'b0, 1'b1, 64'h180, "R9");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule